// File: doc/BRIEF.md
# Multibank DRAM Command Legality Checker

This block sits beside the command path of a multibank graphics SDRAM controller and audits every decoded command as it goes out. For each bank it keeps a small state machine that records whether the row is closed or open and which action, if any, is still running: activating, write burst, write recovery, read burst or precharging. Write and read bursts are tied to the data strobes, so the controller reports the end of each burst with single-cycle pulses. The block also follows the power state of the whole device: normal, power-down or self-refresh.

A command that breaks a rule raises `viol` in the same cycle, combinationally from the command inputs and the stored state, together with a reason code. The block only observes: every command, legal or not, updates the tracked state as though the device had accepted it. All timing spans are compile-time parameters counted in clock cycles.

Per-bank states: `BK_IDLE` (row closed), `BK_OPEN` (row open, no action), `BK_ACTIVATING`, `BK_WR_BURST`, `BK_WR_RECOVER`, `BK_RD_BURST`, `BK_PRECHARGING`.

Bank transitions:
- activate: `BK_ACTIVATING`, or `BK_OPEN` when the span is one cycle.
- read or write: `BK_RD_BURST` or `BK_WR_BURST`, with an autoprecharge flag.
- precharge, or precharge-all for every bank: `BK_PRECHARGING`.
- `BK_ACTIVATING` to `BK_OPEN` when its counter expires.
- `BK_WR_BURST` to `BK_WR_RECOVER` on the write-end pulse.
- `BK_WR_RECOVER` and `BK_RD_BURST` (on the read-end pulse) end in `BK_OPEN`, or in `BK_IDLE` when autoprecharge was requested.
- `BK_PRECHARGING` to `BK_IDLE` when its counter expires.

Power states: `PW_NORMAL`, `PW_PDOWN`, `PW_SREF`.
- `PW_NORMAL` to `PW_PDOWN` on power-down entry.
- `PW_NORMAL` to `PW_SREF` on self-refresh entry.
- Each of the two returns to `PW_NORMAL` only on its own exit command.

Top module: `dram_cmd_guard`

## Requirements
- R1: After synchronous reset every bank is closed with no action and the device is in the normal power state: a NOP is accepted, and an activate to any bank is accepted.
- R2: Command codes on `cmd_code`: 0 NOP, 1 activate, 2 read, 3 read+autoprecharge, 4 write, 5 write+autoprecharge, 6 precharge, 7 precharge-all, 8 power-down entry, 9 power-down exit, 10 self-refresh entry, 11 self-refresh exit, 12 auto refresh, 13 mode-register set, 14 extended mode-register set. Reason codes on `viol_reason`: 0 none, 1 spacing, 2 NOP gap, 3 forbidden, 4 power state. `viol` is high exactly when the reason is nonzero, in the cycle of the command itself. A NOP never flags.
- R3: The following are forbidden (3):
  - an activate to a bank that is open or has an action running;
  - a read or write to a bank that is not open with no action running;
  - a precharge to a bank with an action running.

  An activate keeps its bank busy for T_RCD cycles.
- R4: An activate issued fewer than T_RRD cycles after the previous activate, to any bank, is a spacing violation (1).
- R5: A write action lasts until the write-end pulse and then for T_WR cycles more. A plain write leaves the row open.
- R6: A read (2 or 3) is a spacing violation (1) while any bank is in a write burst, and for fewer than T_WTR cycles after a write-end pulse.
- R7: A write (4 or 5) issued fewer than T_RTW cycles after a read command is a spacing violation (1).
- R8: A write directly after a write, or a read directly after a read, to a different bank with no NOP cycle between them, is a NOP-gap violation (2).
- R9: A read with autoprecharge while another bank runs a write-with-autoprecharge action (burst or recovery) is forbidden (3). A plain read in the same situation is limited only by R6.
- R10: A read action ends at the read-end pulse: from the next cycle the row is open after a plain read and closed after a read with autoprecharge.
- R11: A precharge keeps its bank busy for T_RP cycles. Precharge-all is forbidden (3) while any bank has an action, and closes every bank.
- R12: These commands are forbidden (3) in the following cases:
  - power-down entry while any bank has an action;
  - auto refresh, self-refresh entry or either mode-register set while any bank is open or has an action.

  In the normal state, either exit command is a power-state violation (4).
- R13: In power-down only NOP and power-down exit are legal, and in self-refresh only NOP and self-refresh exit; any other command is a power-state violation (4). The exit returns the device to the normal state.
- R14: When several rules fail, the reason with the highest priority is reported, in the order power (4), forbidden (3), NOP gap (2), spacing (1). Every command updates the tracked state as though accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_code | input | 4 | Decoded command for this cycle |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| wr_strobe_done | input | 1 | One-cycle pulse: the last write strobe edge has been seen |
| rd_strobe_done | input | 1 | One-cycle pulse: the last read strobe edge has been seen |
| viol | output | 1 | Command in this cycle is illegal |
| viol_reason | output | 3 | Reason for the violation, 0 when legal |

## Verification
The verdict is combinational, so the bench drives a command at the falling edge, waits a settling nanosecond and compares `viol`/`viol_reason` before the next rising edge, in the command's own cycle. A span T started by a command (or pulse) sampled at edge t keeps its condition true in cycles t+1 through t+T-1, and frees it in cycle t+T. Each scenario places its probe command exactly at t+T-1 or t+T for the span it tests, counting from the edge that loaded the counter. Every scenario begins with a reset, so that state left over from an earlier command cannot affect the outcome.

// File: rtl/cmdguard_pkg.sv
`timescale 1ns/1ps
package cmdguard_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_RDA  = 4'd3,
        CMD_WR   = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_PREA = 4'd7,
        CMD_PDE  = 4'd8,
        CMD_PDX  = 4'd9,
        CMD_SRE  = 4'd10,
        CMD_SRX  = 4'd11,
        CMD_REF  = 4'd12,
        CMD_MRS  = 4'd13,
        CMD_EMRS = 4'd14
    } cmd_t;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_SPACING = 3'd1,
        RSN_NOPGAP  = 3'd2,
        RSN_FORBID  = 3'd3,
        RSN_POWER   = 3'd4
    } reason_t;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_OPEN,
        BK_ACTIVATING,
        BK_WR_BURST,
        BK_WR_RECOVER,
        BK_RD_BURST,
        BK_PRECHARGING
    } bank_st_t;

    typedef enum logic [1:0] {
        PW_NORMAL,
        PW_PDOWN,
        PW_SREF
    } pwr_st_t;

    function automatic logic is_read(input cmd_t c);
        return (c == CMD_RD) || (c == CMD_RDA);
    endfunction

    function automatic logic is_write(input cmd_t c);
        return (c == CMD_WR) || (c == CMD_WRA);
    endfunction

endpackage

// File: rtl/cmdguard_downcnt.sv
`timescale 1ns/1ps
module cmdguard_downcnt #(
    parameter int CW   = 4,
    parameter int SPAN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(SPAN - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/cmdguard_bank.sv
`timescale 1ns/1ps
module cmdguard_bank
    import cmdguard_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_RCD = 4,
    parameter int T_WR  = 3,
    parameter int T_RP  = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  cmd_t     cmd,
    input  logic     wr_done,
    input  logic     rd_done,
    output bank_st_t st,
    output logic     ap
);
    bank_st_t      st_nx;
    logic          ap_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            ap  <= 1'b0;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            ap  <= ap_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        ap_nx  = ap;
        cnt_nx = cnt;
        if (hit) begin
            unique case (cmd)
                CMD_ACT: begin
                    st_nx  = (T_RCD > 1) ? BK_ACTIVATING : BK_OPEN;
                    cnt_nx = CW'(T_RCD - 1);
                end
                CMD_RD, CMD_RDA: begin
                    st_nx = BK_RD_BURST;
                    ap_nx = (cmd == CMD_RDA);
                end
                CMD_WR, CMD_WRA: begin
                    st_nx = BK_WR_BURST;
                    ap_nx = (cmd == CMD_WRA);
                end
                CMD_PRE, CMD_PREA: begin
                    st_nx  = (T_RP > 1) ? BK_PRECHARGING : BK_IDLE;
                    cnt_nx = CW'(T_RP - 1);
                end
                default: ;
            endcase
        end else begin
            unique case (st)
                BK_ACTIVATING: begin
                    if (cnt <= CW'(1)) st_nx = BK_OPEN;
                    else               cnt_nx = cnt - 1'b1;
                end
                BK_WR_BURST: begin
                    if (wr_done) begin
                        if (T_WR > 1) begin
                            st_nx  = BK_WR_RECOVER;
                            cnt_nx = CW'(T_WR - 1);
                        end else begin
                            st_nx = ap ? BK_IDLE : BK_OPEN;
                        end
                    end
                end
                BK_WR_RECOVER: begin
                    if (cnt <= CW'(1)) st_nx = ap ? BK_IDLE : BK_OPEN;
                    else               cnt_nx = cnt - 1'b1;
                end
                BK_RD_BURST: begin
                    if (rd_done) st_nx = ap ? BK_IDLE : BK_OPEN;
                end
                BK_PRECHARGING: begin
                    if (cnt <= CW'(1)) st_nx = BK_IDLE;
                    else               cnt_nx = cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3
    act_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BK_ACTIVATING && !hit) |=> (st == BK_ACTIVATING || st == BK_OPEN));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == BK_RD_BURST && !hit && !rd_done) |=> (st == BK_RD_BURST));
endmodule

// File: rtl/cmdguard_spacing.sv
`timescale 1ns/1ps
module cmdguard_spacing
    import cmdguard_pkg::*;
#(
    parameter int CW    = 4,
    parameter int BW    = 3,
    parameter int T_RRD = 3,
    parameter int T_WTR = 2,
    parameter int T_RTW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic [BW-1:0] bank,
    input  logic          wr_done,
    output logic          rrd_busy,
    output logic          wtr_busy,
    output logic          rtw_busy,
    output logic          prev_wr,
    output logic          prev_rd,
    output logic [BW-1:0] prev_bank
);
    cmdguard_downcnt #(.CW(CW), .SPAN(T_RRD)) u_rrd (
        .clk(clk), .rst(rst), .load(cmd == CMD_ACT), .busy(rrd_busy));

    cmdguard_downcnt #(.CW(CW), .SPAN(T_WTR)) u_wtr (
        .clk(clk), .rst(rst), .load(wr_done), .busy(wtr_busy));

    cmdguard_downcnt #(.CW(CW), .SPAN(T_RTW)) u_rtw (
        .clk(clk), .rst(rst), .load(is_read(cmd)), .busy(rtw_busy));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_wr   <= 1'b0;
            prev_rd   <= 1'b0;
            prev_bank <= '0;
        end else begin
            prev_wr   <= is_write(cmd);
            prev_rd   <= is_read(cmd);
            prev_bank <= bank;
        end
    end
endmodule

// File: rtl/cmdguard_power.sv
`timescale 1ns/1ps
module cmdguard_power
    import cmdguard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cmd_t    cmd,
    output pwr_st_t pst,
    output logic    pwr_viol
);
    pwr_st_t pst_nx;

    always_ff @(posedge clk) begin
        if (rst) pst <= PW_NORMAL;
        else     pst <= pst_nx;
    end

    always_comb begin
        pst_nx = pst;
        unique case (pst)
            PW_NORMAL: begin
                if (cmd == CMD_PDE)      pst_nx = PW_PDOWN;
                else if (cmd == CMD_SRE) pst_nx = PW_SREF;
            end
            PW_PDOWN: if (cmd == CMD_PDX) pst_nx = PW_NORMAL;
            PW_SREF:  if (cmd == CMD_SRX) pst_nx = PW_NORMAL;
            default:  pst_nx = PW_NORMAL;
        endcase
    end

    always_comb begin
        unique case (pst)
            PW_PDOWN: pwr_viol = !(cmd == CMD_NOP || cmd == CMD_PDX);
            PW_SREF:  pwr_viol = !(cmd == CMD_NOP || cmd == CMD_SRX);
            default:  pwr_viol = (cmd == CMD_PDX) || (cmd == CMD_SRX);
        endcase
    end
endmodule

// File: rtl/dram_cmd_guard.sv
`timescale 1ns/1ps
module dram_cmd_guard
    import cmdguard_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_RCD     = 4,
    parameter int T_RRD     = 3,
    parameter int T_WR      = 3,
    parameter int T_RP      = 3,
    parameter int T_WTR     = 2,
    parameter int T_RTW     = 3,
    localparam int BW       = $clog2(NUM_BANKS),
    localparam int TMAX1    = (T_RCD > T_RRD) ? T_RCD : T_RRD,
    localparam int TMAX2    = (T_WR > T_RP) ? T_WR : T_RP,
    localparam int TMAX3    = (T_WTR > T_RTW) ? T_WTR : T_RTW,
    localparam int TMAX12   = (TMAX1 > TMAX2) ? TMAX1 : TMAX2,
    localparam int TMAX     = (TMAX12 > TMAX3) ? TMAX12 : TMAX3,
    localparam int CW       = $clog2(TMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cmd_code,
    input  logic [BW-1:0] cmd_bank,
    input  logic          wr_strobe_done,
    input  logic          rd_strobe_done,
    output logic          viol,
    output logic [2:0]    viol_reason
);
    cmd_t     cmd;
    bank_st_t bst [NUM_BANKS];
    logic     bap [NUM_BANKS];

    logic [NUM_BANKS-1:0] busy_v, open_v, wburst_v, wra_v, others_v;
    logic    rrd_busy, wtr_busy, rtw_busy, prev_wr, prev_rd;
    logic [BW-1:0] prev_bank;
    pwr_st_t pst;
    logic    pwr_viol;
    logic    forbid, nopgap, spacing;
    reason_t reason;

    assign cmd = cmd_t'(cmd_code);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (cmd == CMD_PREA) ||
                     ((cmd_bank == BW'(g)) &&
                      (cmd == CMD_ACT || is_read(cmd) || is_write(cmd) || cmd == CMD_PRE));

        cmdguard_bank #(.CW(CW), .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP)) u_bank (
            .clk(clk), .rst(rst), .hit(hit), .cmd(cmd),
            .wr_done(wr_strobe_done), .rd_done(rd_strobe_done),
            .st(bst[g]), .ap(bap[g]));

        assign busy_v[g]   = (bst[g] != BK_IDLE) && (bst[g] != BK_OPEN);
        assign open_v[g]   = (bst[g] == BK_OPEN);
        assign wburst_v[g] = (bst[g] == BK_WR_BURST);
        assign wra_v[g]    = bap[g] && (bst[g] == BK_WR_BURST || bst[g] == BK_WR_RECOVER);
        assign others_v[g] = (cmd_bank != BW'(g));
    end

    cmdguard_spacing #(.CW(CW), .BW(BW), .T_RRD(T_RRD), .T_WTR(T_WTR), .T_RTW(T_RTW)) u_spacing (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(cmd_bank), .wr_done(wr_strobe_done),
        .rrd_busy(rrd_busy), .wtr_busy(wtr_busy), .rtw_busy(rtw_busy),
        .prev_wr(prev_wr), .prev_rd(prev_rd), .prev_bank(prev_bank));

    cmdguard_power u_power (
        .clk(clk), .rst(rst), .cmd(cmd), .pst(pst), .pwr_viol(pwr_viol));

    always_comb begin
        forbid = 1'b0;
        unique case (cmd)
            CMD_ACT:                     forbid = busy_v[cmd_bank] || open_v[cmd_bank];
            CMD_RD, CMD_WR, CMD_WRA:     forbid = !open_v[cmd_bank];
            CMD_RDA:                     forbid = !open_v[cmd_bank] || |(wra_v & others_v);
            CMD_PRE:                     forbid = busy_v[cmd_bank];
            CMD_PREA, CMD_PDE:           forbid = |busy_v;
            CMD_REF, CMD_SRE,
            CMD_MRS, CMD_EMRS:           forbid = |(busy_v | open_v);
            default:                     forbid = 1'b0;
        endcase
    end

    assign nopgap = (cmd_bank != prev_bank) &&
                    ((is_write(cmd) && prev_wr) || (is_read(cmd) && prev_rd));

    assign spacing = ((cmd == CMD_ACT) && rrd_busy) ||
                     (is_read(cmd) && (wtr_busy || |wburst_v)) ||
                     (is_write(cmd) && rtw_busy);

    always_comb begin
        if (pwr_viol)     reason = RSN_POWER;
        else if (forbid)  reason = RSN_FORBID;
        else if (nopgap)  reason = RSN_NOPGAP;
        else if (spacing) reason = RSN_SPACING;
        else              reason = RSN_NONE;
    end

    assign viol_reason = reason;
    assign viol        = (reason != RSN_NONE);

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_NOP) |-> !viol);

    // R13
    pdown_only_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pst == PW_PDOWN && cmd != CMD_NOP && cmd != CMD_PDX) |-> (viol && viol_reason == 3'd4));

    if (T_RRD > 1) begin : g_rrd_chk
        // R4
        act_rrd_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd == CMD_ACT) |=> (cmd != CMD_ACT || viol));
    end
endmodule

// File: tb/sim_dram_cmd_guard.sv
`timescale 1ns/1ps
module sim_dram_cmd_guard;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_RDA = 3, C_WR = 4, C_WRA = 5,
                   C_PRE = 6, C_PREA = 7, C_PDE = 8, C_PDX = 9, C_SRE = 10,
                   C_SRX = 11, C_REF = 12, C_MRS = 13;
    localparam int OK = 0, SPC = 1, GAP = 2, FBD = 3, PWR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cmd_code = '0;
    logic [2:0] cmd_bank = '0;
    logic       wr_strobe_done = 1'b0;
    logic       rd_strobe_done = 1'b0;
    logic       viol;
    logic [2:0] viol_reason;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    dram_cmd_guard u0 (
        .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .wr_strobe_done(wr_strobe_done), .rd_strobe_done(rd_strobe_done),
        .viol(viol), .viol_reason(viol_reason));

    always #2.5 clk = ~clk;

    // Drive at the falling edge, sample 1 ns later, before the rising edge.
    task automatic step(input int c, input int b, input bit wp, input bit rp,
                        input int exp, input string tag);
        cmd_code       = 4'(c);
        cmd_bank       = 3'(b);
        wr_strobe_done = wp;
        rd_strobe_done = rp;
        #1;
        checks++;
        if (viol !== (exp != 0) || viol_reason !== 3'(exp)) begin
            fails++;
            $display("FAIL %s: viol=%0b reason=%0d expected reason=%0d", tag, viol, viol_reason, exp);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_code = '0; cmd_bank = '0; wr_strobe_done = 1'b0; rd_strobe_done = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Opens banks 0 and 1; leaves both open with all spans expired.
    task automatic open2();
        step(C_ACT, 0, 0, 0, OK, "R1 open b0");
        step(C_NOP, 0, 0, 0, OK, "R2 nop");
        step(C_NOP, 0, 0, 0, OK, "R2 nop");
        step(C_ACT, 1, 0, 0, OK, "R4 act after span");
        repeat (3) step(C_NOP, 0, 0, 0, OK, "R2 nop");
    endtask

    task automatic t_reset();
        do_reset();
        step(C_NOP, 0, 0, 0, OK, "R1 nop after reset");
        step(C_ACT, 3, 0, 0, OK, "R1 act after reset");
    endtask

    task automatic t_activate();
        do_reset();
        step(C_RD, 2, 0, 0, FBD, "R3 read closed bank");
        do_reset();
        step(C_ACT, 0, 0, 0, OK, "R3 act");
        step(C_NOP, 0, 0, 0, OK, "R3 nop");
        step(C_NOP, 0, 0, 0, OK, "R3 nop");
        step(C_RD, 0, 0, 0, FBD, "R3 read at tRCD-1");
        do_reset();
        step(C_ACT, 0, 0, 0, OK, "R3 act");
        repeat (3) step(C_NOP, 0, 0, 0, OK, "R3 nop");
        step(C_RD, 0, 0, 0, OK, "R3 read at tRCD");
    endtask

    task automatic t_rrd();
        do_reset();
        step(C_ACT, 0, 0, 0, OK, "R4 act");
        step(C_PRE, 5, 0, 0, OK, "R3 pre other bank during activate");
        step(C_ACT, 1, 0, 0, SPC, "R4 act at tRRD-1");
        do_reset();
        step(C_ACT, 0, 0, 0, OK, "R4 act");
        step(C_NOP, 0, 0, 0, OK, "R4 nop");
        step(C_NOP, 0, 0, 0, OK, "R4 nop");
        step(C_ACT, 1, 0, 0, OK, "R4 act at tRRD");
    endtask

    task automatic t_write();
        do_reset(); open2();
        step(C_WR, 0, 0, 0, OK, "R5 write");
        step(C_NOP, 0, 0, 0, OK, "R6 nop");
        step(C_NOP, 0, 0, 0, OK, "R6 nop");
        step(C_RD, 1, 0, 0, SPC, "R6 read during write burst");
        do_reset(); open2();
        step(C_WR, 0, 0, 0, OK, "R5 write");
        step(C_NOP, 0, 1, 0, OK, "R5 write end pulse");
        step(C_RD, 1, 0, 0, SPC, "R6 read at tWTR-1");
        do_reset(); open2();
        step(C_WR, 0, 0, 0, OK, "R5 write");
        step(C_NOP, 0, 1, 0, OK, "R5 write end pulse");
        step(C_NOP, 0, 0, 0, OK, "R5 nop");
        step(C_RD, 0, 0, 0, FBD, "R5 read during write recovery");
        do_reset(); open2();
        step(C_WR, 0, 0, 0, OK, "R5 write");
        step(C_NOP, 0, 1, 0, OK, "R5 write end pulse");
        step(C_NOP, 0, 0, 0, OK, "R5 nop");
        step(C_NOP, 0, 0, 0, OK, "R5 nop");
        step(C_RD, 0, 0, 0, OK, "R5 read after tWR, row open");
    endtask

    task automatic t_rtw();
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R7 read");
        step(C_NOP, 0, 0, 0, OK, "R7 nop");
        step(C_WR, 1, 0, 0, SPC, "R7 write at tRTW-1");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R7 read");
        step(C_NOP, 0, 0, 0, OK, "R7 nop");
        step(C_NOP, 0, 0, 0, OK, "R7 nop");
        step(C_WR, 1, 0, 0, OK, "R7 write at tRTW");
    endtask

    task automatic t_nopgap();
        do_reset(); open2();
        step(C_WR, 0, 0, 0, OK, "R8 write");
        step(C_WR, 1, 0, 0, GAP, "R8 write back to back");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R8 read");
        step(C_RD, 1, 0, 0, GAP, "R8 read back to back");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R8 read");
        step(C_NOP, 0, 0, 0, OK, "R8 nop");
        step(C_RD, 1, 0, 0, OK, "R8 read after one nop");
    endtask

    task automatic t_wra();
        do_reset(); open2();
        step(C_WRA, 0, 0, 0, OK, "R9 write ap");
        step(C_NOP, 0, 1, 0, OK, "R9 write end pulse");
        step(C_NOP, 0, 0, 0, OK, "R9 nop");
        step(C_RDA, 1, 0, 0, FBD, "R9 read ap during write ap");
        do_reset(); open2();
        step(C_WRA, 0, 0, 0, OK, "R9 write ap");
        step(C_NOP, 0, 1, 0, OK, "R9 write end pulse");
        step(C_NOP, 0, 0, 0, OK, "R9 nop");
        step(C_RD, 1, 0, 0, OK, "R9 plain read after tWTR");
    endtask

    task automatic t_read();
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R10 read");
        step(C_NOP, 0, 0, 0, OK, "R10 nop");
        step(C_RD, 0, 0, 0, FBD, "R10 read before end pulse");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R10 read");
        step(C_NOP, 0, 0, 1, OK, "R10 read end pulse");
        step(C_RD, 0, 0, 0, OK, "R10 row stays open");
        do_reset(); open2();
        step(C_RDA, 0, 0, 0, OK, "R10 read ap");
        step(C_NOP, 0, 0, 1, OK, "R10 read end pulse");
        step(C_ACT, 0, 0, 0, OK, "R10 row closed after read ap");
    endtask

    task automatic t_precharge();
        do_reset(); open2();
        step(C_PRE, 0, 0, 0, OK, "R11 pre");
        step(C_NOP, 0, 0, 0, OK, "R11 nop");
        step(C_ACT, 0, 0, 0, FBD, "R11 act at tRP-1");
        do_reset(); open2();
        step(C_PRE, 0, 0, 0, OK, "R11 pre");
        step(C_NOP, 0, 0, 0, OK, "R11 nop");
        step(C_NOP, 0, 0, 0, OK, "R11 nop");
        step(C_ACT, 0, 0, 0, OK, "R11 act at tRP");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R11 read");
        step(C_PREA, 0, 0, 0, FBD, "R11 pre-all during action");
        do_reset(); open2();
        step(C_PREA, 0, 0, 0, OK, "R11 pre-all");
        step(C_NOP, 0, 0, 0, OK, "R11 nop");
        step(C_NOP, 0, 0, 0, OK, "R11 nop");
        step(C_REF, 0, 0, 0, OK, "R11 refresh after pre-all closes all");
    endtask

    task automatic t_power();
        do_reset();
        step(C_PDX, 0, 0, 0, PWR, "R12 power-down exit in normal");
        step(C_SRX, 0, 0, 0, PWR, "R12 self-refresh exit in normal");
        do_reset(); open2();
        step(C_REF, 0, 0, 0, FBD, "R12 refresh with open rows");
        do_reset(); open2();
        step(C_RD, 0, 0, 0, OK, "R12 read");
        step(C_PDE, 0, 0, 0, FBD, "R12 power-down entry during action");
        do_reset(); open2();
        step(C_PDE, 0, 0, 0, OK, "R12 power-down entry rows open");
        step(C_ACT, 2, 0, 0, PWR, "R13 act in power-down");
        step(C_PDX, 0, 0, 0, OK, "R13 power-down exit");
        step(C_NOP, 0, 0, 0, OK, "R13 normal after exit");
        do_reset();
        step(C_SRE, 0, 0, 0, OK, "R13 self-refresh entry");
        step(C_PDX, 0, 0, 0, PWR, "R13 wrong exit in self-refresh");
        step(C_SRX, 0, 0, 0, OK, "R13 self-refresh exit");
        step(C_MRS, 0, 0, 0, OK, "R12 mode set when all closed");
    endtask

    task automatic t_priority();
        do_reset();
        step(C_PDE, 0, 0, 0, OK, "R14 power-down entry");
        step(C_RD, 0, 0, 0, PWR, "R14 power beats forbidden");
        do_reset(); open2();
        step(C_WRA, 0, 0, 0, OK, "R14 write ap");
        step(C_NOP, 0, 0, 0, OK, "R14 nop");
        step(C_RDA, 1, 0, 0, FBD, "R14 forbidden beats spacing");
        do_reset();
        step(C_RD, 0, 0, 0, FBD, "R14 illegal read");
        step(C_PRE, 0, 0, 0, FBD, "R14 state updated as though accepted");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #20000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_activate();
        t_rrd();
        t_write();
        t_rtw();
        t_nopgap();
        t_wra();
        t_read();
        t_precharge();
        t_power();
        t_priority();
        summary();
    end
endmodule